// File: doc/BRIEF.md
# Armed Up-Counting Interrupt Timer

This block is a 16-bit interrupt timer for a cartridge adapter. Software loads the count in two byte writes on the CPU bus. The high-byte write also arms the timer. While armed, the count climbs one step per tick. The tick that arrives when the count already holds all ones raises the interrupt and disarms the timer.

Ticks come from one of two places, chosen by a mode input. With the mode input low, every CPU-cycle strobe is one tick. With the mode input high, every scanline strobe is a burst of eight ticks, and CPU-cycle strobes are ignored. A burst is applied in a single clock, but the result is the same as eight single ticks: the all-ones check is made on every value the burst passes through.

The interrupt is a level that stays high until software acknowledges it. Any write to the timer's own registers acknowledges it, and so do writes to two separate acknowledge addresses. The scanline strobe comes from outside the block.

Top module: `cart_upcount_irq`

## Requirements
- R1: After synchronous reset, `irq` is 0, the count is zero and the timer is disarmed, so ticks raise no interrupt until the timer is armed.
- R2: A write to 0x4502 replaces bits 7:0 of the count with the data byte and drops `irq`. It does not arm the timer.
- R3: A write to 0x4503 replaces bits 15:8 of the count with the data byte, arms the timer and drops `irq`.
- R4: A write to 0x4501 disarms the timer and drops `irq`. While disarmed, the count holds its value, and re-arming resumes from that held value.
- R5: On each tick while armed, a count of 0xFFFF raises `irq` and disarms the timer, leaving the count at 0xFFFF. Any other count is incremented by one. Starting from a loaded value v, in CPU-cycle mode the interrupt therefore appears on tick 0x10000 - v.
- R6: With `line_mode` = 0, each clock with `cpu_tick` high is one tick, and `line_tick` has no effect.
- R7: With `line_mode` = 1, each clock with `line_tick` high counts as eight ticks, and `cpu_tick` has no effect. From a loaded value v, the interrupt appears on scanline strobe number ceil((0x10000 - v) / 8).
- R8: A write to 0x4024 or to 0x4025 drops `irq` and changes neither the count nor the armed state.
- R9: `irq` is a level. Once raised, it stays high until one of the acknowledging writes.
- R10: In a clock where 0x4501, 0x4502 or 0x4503 is written, that clock's ticks are discarded. If a tick raises the interrupt in the same clock as a write to 0x4024 or 0x4025, the raise wins.
- R11: All effects are registered. A write or tick sampled at a rising clock edge shows on `irq` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one clock per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_tick | input | 1 | One pulse per CPU cycle |
| line_tick | input | 1 | One pulse per scanline |
| line_mode | input | 1 | Tick source: 0 = CPU cycles, 1 = eight ticks per scanline |
| irq | output | 1 | Interrupt level, active high |

## Verification
Loaded values sit at several distances from the wrap point, in both tick modes. A design that checks all ones only at the end of a burst would fire a scanline late for values that are not multiples of eight away. A design that fires at zero instead of after all ones would fire one tick late everywhere. Other cases pause the count with a disarm and then re-arm it: a timer that keeps counting while disarmed, or that reloads on arming, fires at the wrong tick. The same-clock collisions are also checked. A design that lets a tick through during a register write, or that lets an acknowledge beat a raise in the same clock, shows a different `irq` in that clock.

// File: rtl/upirq_pkg.sv
package upirq_pkg;

    // Default register addresses of the timer
    localparam logic [15:0] ADDR_DISARM  = 16'h4501;
    localparam logic [15:0] ADDR_CNT_LO  = 16'h4502;
    localparam logic [15:0] ADDR_CNT_HI  = 16'h4503;
    localparam logic [15:0] ADDR_ACK_A   = 16'h4024;
    localparam logic [15:0] ADDR_ACK_B   = 16'h4025;

    // Decoded register command for one clock
    typedef struct packed {
        logic set_lo;
        logic set_hi;
        logic disarm;
        logic ack;
    } reg_cmd_t;

    // Tick source selection
    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_LINE = 1'b1
    } tick_src_e;

    function automatic logic is_count_write(input reg_cmd_t c);
        return c.set_lo | c.set_hi | c.disarm;
    endfunction

endpackage

// File: rtl/upirq_decode.sv
module upirq_decode
    import upirq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] A_DISARM  = ADDR_DISARM,
    parameter logic [15:0] A_LO      = ADDR_CNT_LO,
    parameter logic [15:0] A_HI      = ADDR_CNT_HI,
    parameter logic [15:0] A_ACK_A   = ADDR_ACK_A,
    parameter logic [15:0] A_ACK_B   = ADDR_ACK_B
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output reg_cmd_t          cmd
);

    logic hit_dis, hit_lo, hit_hi, hit_ack;

    always_comb begin
        hit_dis = wr_en && (wr_addr == ADDR_W'(A_DISARM));
        hit_lo  = wr_en && (wr_addr == ADDR_W'(A_LO));
        hit_hi  = wr_en && (wr_addr == ADDR_W'(A_HI));
        hit_ack = wr_en && ((wr_addr == ADDR_W'(A_ACK_A)) ||
                            (wr_addr == ADDR_W'(A_ACK_B)));
        cmd.set_lo = hit_lo;
        cmd.set_hi = hit_hi;
        cmd.disarm = hit_dis;
        cmd.ack    = hit_ack | hit_dis | hit_lo | hit_hi;
    end

endmodule

// File: rtl/upirq_tick.sv
module upirq_tick
    import upirq_pkg::*;
#(
    parameter int BURST_TICKS = 8,
    parameter int AMT_W       = $clog2(BURST_TICKS + 1)
) (
    input  logic             cpu_tick,
    input  logic             line_tick,
    input  logic             line_mode,
    output logic [AMT_W-1:0] tick_amt
);

    tick_src_e src;

    always_comb begin
        src = tick_src_e'(line_mode);
        unique case (src)
            SRC_LINE: tick_amt = line_tick ? AMT_W'(BURST_TICKS) : '0;
            default:  tick_amt = cpu_tick  ? AMT_W'(1)           : '0;
        endcase
    end

endmodule

// File: rtl/upirq_core.sv
module upirq_core
    import upirq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int AMT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AMT_W-1:0]  tick_amt,
    output logic              irq_o
);

    localparam int               HI_W     = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] count;
    logic             armed;
    logic             reg_write;
    logic [CNT_W-1:0] room;
    logic [CNT_W:0]   amt_ext;
    logic [CNT_W-1:0] count_step;
    logic             fire;

    always_comb begin
        reg_write  = is_count_write(cmd);
        room       = ALL_ONES - count;
        amt_ext    = {{(CNT_W + 1 - AMT_W){1'b0}}, tick_amt};
        // A burst fires if it holds more ticks than steps left to all ones
        fire       = armed && !reg_write && (amt_ext > {1'b0, room});
        count_step = count + amt_ext[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            armed <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            if (reg_write) begin
                if (cmd.set_lo) count[DATA_W-1:0] <= wr_data;
                if (cmd.set_hi) begin
                    count[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
                    armed <= 1'b1;
                end
                if (cmd.disarm) armed <= 1'b0;
            end else if (armed) begin
                if (fire) begin
                    count <= ALL_ONES;
                    armed <= 1'b0;
                end else begin
                    count <= count_step;
                end
            end
            if (fire)         irq_o <= 1'b1;
            else if (cmd.ack) irq_o <= 1'b0;
        end
    end

    // R5: a raised interrupt leaves the timer disarmed
    p_fire_disarms_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> !armed);

    // R5: only an armed timer can raise the interrupt
    p_fire_needs_arm_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(armed));

    // R4: the disarm write leaves the timer idle with no interrupt
    p_disarm_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.disarm |=> (!armed && !irq_o));

    // R4: a disarmed timer holds its count
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!armed && !cmd.set_lo && !cmd.set_hi) |=> $stable(count));

    // R2: the low-byte write drops the interrupt
    p_lo_ack_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.set_lo |=> !irq_o);

    // R3: the high-byte write arms the timer
    p_hi_arms_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.set_hi && !cmd.disarm) |=> armed);

    // R9: the interrupt level holds without an acknowledge
    p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !cmd.ack) |=> irq_o);

endmodule

// File: rtl/cart_upcount_irq.sv
module cart_upcount_irq
    import upirq_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          CNT_W       = 16,
    parameter int          BURST_TICKS = 8,
    parameter logic [15:0] A_DISARM    = ADDR_DISARM,
    parameter logic [15:0] A_LO        = ADDR_CNT_LO,
    parameter logic [15:0] A_HI        = ADDR_CNT_HI,
    parameter logic [15:0] A_ACK_A     = ADDR_ACK_A,
    parameter logic [15:0] A_ACK_B     = ADDR_ACK_B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpu_tick,
    input  logic              line_tick,
    input  logic              line_mode,
    output logic              irq
);

    localparam int AMT_W = $clog2(BURST_TICKS + 1);

    reg_cmd_t         cmd;
    logic [AMT_W-1:0] tick_amt;

    upirq_decode #(
        .ADDR_W   (ADDR_W),
        .A_DISARM (A_DISARM),
        .A_LO     (A_LO),
        .A_HI     (A_HI),
        .A_ACK_A  (A_ACK_A),
        .A_ACK_B  (A_ACK_B)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd)
    );

    upirq_tick #(
        .BURST_TICKS (BURST_TICKS),
        .AMT_W       (AMT_W)
    ) u_tick (
        .cpu_tick  (cpu_tick),
        .line_tick (line_tick),
        .line_mode (line_mode),
        .tick_amt  (tick_amt)
    );

    upirq_core #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wr_data  (wr_data),
        .tick_amt (tick_amt),
        .irq_o    (irq)
    );

endmodule

// File: tb/cart_upcount_irq_tb.sv
module cart_upcount_irq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cpu_tick = 1'b0;
    logic        line_tick = 1'b0;
    logic        line_mode = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cart_upcount_irq u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cpu_tick  (cpu_tick),
        .line_tick (line_tick),
        .line_mode (line_mode),
        .irq       (irq)
    );

    // {mode, start value}: mode 0 = CPU cycles, 1 = scanline bursts
    localparam logic [16:0] VECS [9] = '{
        {1'b0, 16'hFFFF}, {1'b0, 16'hFFFE}, {1'b0, 16'hFF00},
        {1'b0, 16'h0000}, {1'b1, 16'hFFFF}, {1'b1, 16'hFFF8},
        {1'b1, 16'hFFF7}, {1'b1, 16'hFF00}, {1'b1, 16'h8000}
    };

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (irq !== exp) begin
            n_fails++;
            $display("FAIL %s: irq=%b expected %b at %0t", req, irq, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(16'h4502, v[7:0]);
        wr(16'h4503, v[15:8]);
    endtask

    task automatic pulses(input int n, input bit use_line);
        if (n > 0) begin
            @(negedge clk);
            if (use_line) line_tick = 1'b1; else cpu_tick = 1'b1;
            repeat (n) @(negedge clk);
            line_tick = 1'b0; cpu_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset irq low", 1'b0);
        pulses(20, 1'b0);
        check("R1 disarmed after reset", 1'b0);

        // Table walk: R5 CPU-cycle firing, R7 scanline firing
        for (int i = 0; i < 9; i++) begin
            logic [15:0] v;
            bit          m;
            int          n;
            v = VECS[i][15:0];
            m = VECS[i][16];
            n = m ? ((32'h10000 - v + 7) / 8) : (32'h10000 - v);
            line_mode = m;
            load(v);
            if (n > 1) begin
                pulses(n - 1, m);
                check(m ? "R7 no fire before last line" : "R5 no fire before wrap", 1'b0);
            end
            pulses(1, m);
            check(m ? "R7 fire on burst" : "R5 fire after all ones", 1'b1);
            wr(16'h4024, 8'h00);
            check("R8 ack 4024 drops irq", 1'b0);
        end

        // R5: after firing the timer is disarmed; later ticks do not refire
        line_mode = 1'b0;
        load(16'hFFFF);
        pulses(1, 1'b0);
        check("R5 fire", 1'b1);
        wr(16'h4025, 8'h00);
        check("R8 ack 4025 drops irq", 1'b0);
        pulses(10, 1'b0);
        check("R5 disarmed after fire", 1'b0);

        // R9: level holds
        load(16'hFFFF);
        pulses(1, 1'b0);
        repeat (10) @(negedge clk);
        check("R9 irq held", 1'b1);
        // R2: low write acknowledges, does not arm
        wr(16'h4502, 8'hFF);
        check("R2 low write acks", 1'b0);
        pulses(5, 1'b0);
        check("R2 low write does not arm", 1'b0);
        // R3: high write acknowledges
        load(16'hFFFF);
        pulses(1, 1'b0);
        wr(16'h4503, 8'hFF);
        check("R3 high write acks", 1'b0);
        pulses(1, 1'b0);
        check("R3 high write arms", 1'b1);
        // R4: disarm acknowledges
        wr(16'h4501, 8'h00);
        check("R4 disarm acks", 1'b0);

        // R4: count held while disarmed, resumes from held value
        load(16'hFFF0);
        pulses(14, 1'b0);
        wr(16'h4501, 8'h00);
        pulses(20, 1'b0);
        check("R4 no fire while disarmed", 1'b0);
        wr(16'h4503, 8'hFF);
        pulses(1, 1'b0);
        check("R4 held value resumes", 1'b0);
        pulses(1, 1'b0);
        check("R4 fire from held value", 1'b1);
        wr(16'h4024, 8'h00);

        // R6: line strobe ignored in CPU mode
        line_mode = 1'b0;
        load(16'hFFFF);
        pulses(4, 1'b1);
        check("R6 line ignored in cpu mode", 1'b0);
        pulses(1, 1'b0);
        check("R6 cpu tick counts", 1'b1);
        wr(16'h4024, 8'h00);

        // R7: CPU strobe ignored in line mode
        line_mode = 1'b1;
        load(16'hFFF9);
        pulses(50, 1'b0);
        check("R7 cpu ignored in line mode", 1'b0);
        pulses(1, 1'b1);
        check("R7 one burst fires", 1'b1);
        wr(16'h4024, 8'h00);
        line_mode = 1'b0;

        // R10: tick in the same clock as the arming write is dropped
        wr(16'h4502, 8'hFE);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h4503; wr_data = 8'hFF; cpu_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R10 tick during write dropped", 1'b0);
        @(negedge clk);
        cpu_tick = 1'b0;
        check("R10 fire after dropped tick", 1'b1);
        wr(16'h4024, 8'h00);

        // R10: raise beats a same-clock acknowledge
        load(16'hFFFF);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h4024; cpu_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cpu_tick = 1'b0;
        check("R10 raise wins over ack", 1'b1);
        // R11: ack visible right after the edge
        wr(16'h4025, 8'h00);
        check("R11 ack registered", 1'b0);

        // R1: reset clears an armed timer and a raised interrupt
        load(16'hFFFF);
        pulses(1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears irq", 1'b0);
        pulses(3, 1'b0);
        check("R1 reset disarms", 1'b0);

        finish_run();
    end

endmodule